// File: doc/BRIEF.md
# Delta Color Block Compressor

This block takes one color block of 64 pixels, 32 bits each, with four 8-bit channels, and packs it without loss. Pixels arrive one per cycle over a valid/ready handshake and are held in an internal buffer. While they arrive, the block tracks the narrowest signed delta width that can describe every channel of every pixel relative to pixel 0, which serves as the anchor.

Once all 64 pixels are in, the block streams the packed form as 256-bit sectors over a second valid/ready handshake. Each sector is sent with a 4-bit header and the sector count of the block. The anchor is sent verbatim. All other pixels are sent as per-channel deltas of 0, 2 or 4 bits, padded with zeros to a whole sector. If no narrow width fits, or if the packed form would need as many sectors as the raw data, the block is sent raw in 8 sectors.

A downstream unit rebuilds each channel as the anchor channel plus the sign-extended delta, modulo 256.

Top module: `dcc_block_packer`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A pixel is taken on every clock edge where `in_valid` and `in_ready` are both 1. On the edge that takes the 64th pixel, `in_ready` drops to 0 and `out_valid` rises. No pixel is taken while sectors are being sent.
- R3: If every pixel equals pixel 0, the header is 0 and one sector is sent. Bits [31:0] of that sector hold the anchor and all other bits are zero.
- R4: If every channel delta lies in [-2, 1] and at least one is non-zero, the header is 2 and 3 sectors are sent. The packed stream holds the anchor at bits [31:0]. The delta of pixel p (1..63), channel c, is at stream bits 32+2*(4*(p-1)+c) and up. Channel c is pixel bits [8c+7:8c]. Sector k carries stream bits [256k+255:256k]. Bits past the end of the stream are zero.
- R5: Otherwise, if every delta lies in [-8, 7], the header is 4 and 5 sectors are sent. The layout is the same as in R4 but with 4-bit fields at 32+4*(4*(p-1)+c).
- R6: Otherwise the header is 0xF and 8 sectors are sent. Pixel i is at stream bits [32i+31:32i], so sector k holds pixels 8k to 8k+7.
- R7: A delta is the channel difference modulo 256, read as a signed 8-bit value. For example, anchor channel 0xFF and pixel channel 0x00 give a delta of +1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_mode` and `out_count` hold their values. The sector index advances only on an accepted transfer.
- R9: `out_last` is 1 on the final sector only. After that sector is accepted, `in_ready` returns to 1 and the width choice for the next block starts fresh.
- R10: Decoding the sectors with the header gives back the 64 input pixels exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Block accepts a pixel |
| in_pixel | input | 32 | Pixel, four 8-bit channels |
| out_valid | output | 1 | Sector present |
| out_ready | input | 1 | Downstream accepts the sector |
| out_data | output | 256 | Packed sector |
| out_mode | output | 4 | Header: delta width 0/2/4, or 0xF for raw |
| out_count | output | 4 | Sectors in this block |
| out_last | output | 1 | Final sector of the block |

## Verification
The first sector is due at once after the edge that takes the 64th pixel: the width flags and the state are registered on that edge, and the sector mux is combinational. The driver therefore checks `out_valid` and `in_ready` at the falling edge that follows. Each later sector is due on the cycle after an accepted transfer. The monitor samples only at falling edges, pops one expected sector for each transfer it sees there, and checks that a stalled sector has not changed one cycle later. Once a block's last sector has arrived, the monitor decodes the collected sectors and compares them with the pixels that were sent.

// File: rtl/dcc_block_packer.sv
module dcc_block_packer #(
  parameter int CH_W   = 8,
  parameter int NCH    = 4,
  parameter int NPIX   = 64,
  parameter int SECT_W = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CH_W*NCH-1:0]  in_pixel,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SECT_W-1:0]    out_data,
  output logic [3:0]           out_mode,
  output logic [3:0]           out_count,
  output logic                 out_last
);
  localparam int PIX_W    = CH_W * NCH;
  localparam int BLK_W    = PIX_W * NPIX;
  localparam int NDELTA   = (NPIX - 1) * NCH;
  localparam int MAX_SECT = BLK_W / SECT_W;
  localparam int CNT_W    = $clog2(NPIX);
  localparam int SEC_W    = $clog2(MAX_SECT);
  localparam int S0 = (PIX_W + SECT_W - 1) / SECT_W;
  localparam int S2 = (PIX_W + NDELTA * 2 + SECT_W - 1) / SECT_W;
  localparam int S4 = (PIX_W + NDELTA * 4 + SECT_W - 1) / SECT_W;
  localparam logic [3:0] MODE_RAW = 4'hF;

  logic [PIX_W-1:0] pix_q [NPIX];
  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] sect;
  logic             sending;
  logic             fit0, fit2, fit4;
  logic [NCH-1:0]   nz_c, ok2_c, ok4_c;
  logic [BLK_W-1:0] s0, s2, s4, sraw, sel;

  assign in_ready  = !sending;
  assign out_valid = sending;

  for (genvar c = 0; c < NCH; c++) begin : g_in_fit
    logic [CH_W-1:0] dc;
    assign dc       = in_pixel[c*CH_W +: CH_W] - pix_q[0][c*CH_W +: CH_W];
    assign nz_c[c]  = |dc;
    assign ok2_c[c] = (&dc[CH_W-1:1]) | ~(|dc[CH_W-1:1]);
    assign ok4_c[c] = (&dc[CH_W-1:3]) | ~(|dc[CH_W-1:3]);
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_raw
    assign sraw[i*PIX_W +: PIX_W] = pix_q[i];
  end

  for (genvar k = 0; k < NDELTA; k++) begin : g_delta
    localparam int P = k / NCH + 1;
    localparam int C = k % NCH;
    logic [CH_W-1:0] d;
    assign d = pix_q[P][C*CH_W +: CH_W] - pix_q[0][C*CH_W +: CH_W];
    assign s2[PIX_W + 2*k +: 2] = d[1:0];
    assign s4[PIX_W + 4*k +: 4] = d[3:0];
  end

  assign s0 = {{(BLK_W-PIX_W){1'b0}}, pix_q[0]};
  assign s2[PIX_W-1:0] = pix_q[0];
  assign s4[PIX_W-1:0] = pix_q[0];
  assign s2[BLK_W-1:PIX_W+2*NDELTA] = '0;
  assign s4[BLK_W-1:PIX_W+4*NDELTA] = '0;

  always_comb begin
    if (fit0 && S0 < MAX_SECT) begin
      out_mode = 4'd0; out_count = 4'(S0); sel = s0;
    end else if (fit2 && S2 < MAX_SECT) begin
      out_mode = 4'd2; out_count = 4'(S2); sel = s2;
    end else if (fit4 && S4 < MAX_SECT) begin
      out_mode = 4'd4; out_count = 4'(S4); sel = s4;
    end else begin
      out_mode = MODE_RAW; out_count = 4'(MAX_SECT); sel = sraw;
    end
  end

  assign out_data = sel[sect*SECT_W +: SECT_W];
  assign out_last = (4'(sect) == out_count - 4'd1);

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) pix_q[cnt] <= in_pixel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending <= 1'b0;
      cnt     <= '0;
      sect    <= '0;
      fit0    <= 1'b1;
      fit2    <= 1'b1;
      fit4    <= 1'b1;
    end else begin
      if (in_valid && in_ready) begin
        if (cnt == '0) begin
          fit0 <= 1'b1;
          fit2 <= 1'b1;
          fit4 <= 1'b1;
        end else begin
          fit0 <= fit0 & ~(|nz_c);
          fit2 <= fit2 & (&ok2_c);
          fit4 <= fit4 & (&ok4_c);
        end
        if (cnt == CNT_W'(NPIX - 1)) begin
          cnt     <= '0;
          sending <= 1'b1;
          sect    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (out_valid && out_ready) begin
        if (out_last) sending <= 1'b0;
        else          sect    <= sect + 1'b1;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mode) && $stable(out_count));
  assert_start_after_intake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
  assert_continue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);
  assert_raw_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_count == 4'(MAX_SECT) |-> out_mode == MODE_RAW);
endmodule

// File: tb/dcc_block_packer_bench.sv
module dcc_block_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 200000;

  typedef struct {
    logic [255:0] d;
    logic [3:0]   m;
    logic [3:0]   n;
    logic         last;
    string        tag;
  } sect_t;

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [31:0] in_pixel = '0;
  logic in_ready, out_valid, out_last;
  logic [255:0] out_data;
  logic [3:0] out_mode, out_count;

  int checks = 0, errors = 0;
  sect_t exp_q[$];
  logic [2047:0] orig_q[$];
  logic [31:0] blk [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  dcc_block_packer u_dcc_block_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mode(out_mode), .out_count(out_count),
    .out_last(out_last));

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  always @(posedge clk) begin
    #1 out_ready <= ($urandom % 4) != 0;
  end

  logic         stall_prev = 0;
  logic [255:0] held_d;
  logic [3:0]   held_m, held_n;
  logic [2047:0] acc = '0;
  int           k_acc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        check(out_valid && out_data == held_d && out_mode == held_m && out_count == held_n, "R8",
              $sformatf("stalled sector changed: mode %h/%h count %0d/%0d", out_mode, held_m, out_count, held_n));
      stall_prev = out_valid && !out_ready;
      held_d = out_data; held_m = out_mode; held_n = out_count;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected sector: actual out_valid 1, expected 0");
        end else begin
          sect_t e;
          e = exp_q.pop_front();
          check(out_data == e.d && out_mode == e.m && out_count == e.n && out_last == e.last, e.tag,
                $sformatf("sector mode %h count %0d last %b data %h, expected mode %h count %0d last %b data %h",
                          out_mode, out_count, out_last, out_data, e.m, e.n, e.last, e.d));
          acc[256*k_acc +: 256] = out_data;
          k_acc++;
          if (out_last) begin
            logic [2047:0] o, rec;
            o = orig_q.pop_front();
            rec = '0;
            for (int i = 0; i < 64; i++) begin
              if (out_mode == 4'hF) rec[32*i +: 32] = acc[32*i +: 32];
              else if (i == 0) rec[31:0] = acc[31:0];
              else begin
                for (int c = 0; c < 4; c++) begin
                  int idx;
                  logic [7:0] dl;
                  idx = 4*(i-1) + c;
                  if (out_mode == 4'd2) dl = {{6{acc[32+2*idx+1]}}, acc[32+2*idx +: 2]};
                  else if (out_mode == 4'd4) dl = {{4{acc[32+4*idx+3]}}, acc[32+4*idx +: 4]};
                  else dl = 8'd0;
                  rec[32*i + 8*c +: 8] = acc[8*c +: 8] + dl;
                end
              end
            end
            check(rec == o, "R10", $sformatf("decoded block %h, expected %h", rec, o));
            k_acc = 0;
            acc = '0;
          end
        end
      end
    end
  end

  task automatic put(input logic [31:0] p);
    @(negedge clk);
    in_valid = 1; in_pixel = p;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send_block(input string tag);
    bit f0 = 1, f2 = 1, f4 = 1;
    logic [3:0] m, n;
    logic [2047:0] st = '0, o = '0;
    for (int i = 1; i < 64; i++)
      for (int c = 0; c < 4; c++) begin
        logic signed [7:0] sd;
        sd = blk[i][8*c +: 8] - blk[0][8*c +: 8];
        if (sd != 0) f0 = 0;
        if (sd < -2 || sd > 1) f2 = 0;
        if (sd < -8 || sd > 7) f4 = 0;
      end
    if (f0) begin m = 0; n = 1; end
    else if (f2) begin m = 2; n = 3; end
    else if (f4) begin m = 4; n = 5; end
    else begin m = 4'hF; n = 8; end
    for (int i = 0; i < 64; i++) o[32*i +: 32] = blk[i];
    if (m == 4'hF) st = o;
    else begin
      st[31:0] = blk[0];
      for (int i = 1; i < 64; i++)
        for (int c = 0; c < 4; c++) begin
          int idx;
          logic [7:0] d;
          idx = 4*(i-1) + c;
          d = blk[i][8*c +: 8] - blk[0][8*c +: 8];
          if (m == 2) st[32+2*idx +: 2] = d[1:0];
          if (m == 4) st[32+4*idx +: 4] = d[3:0];
        end
    end
    for (int k = 0; k < n; k++) begin
      sect_t s;
      s.d = st[256*k +: 256]; s.m = m; s.n = n; s.last = (k == n-1); s.tag = tag;
      exp_q.push_back(s);
    end
    orig_q.push_back(o);
    for (int i = 0; i < 64; i++) put(blk[i]);
    @(negedge clk);
    in_valid = 0;
    check(out_valid == 1 && in_ready == 0, "R2",
          $sformatf("after 64th pixel out_valid %b in_ready %b, expected 1 0", out_valid, in_ready));
  endtask

  function automatic logic [31:0] add_d(input logic [31:0] a, input int d0, input int d1, input int d2, input int d3);
    logic [31:0] r;
    r[7:0] = a[7:0] + 8'(d0); r[15:8] = a[15:8] + 8'(d1);
    r[23:16] = a[23:16] + 8'(d2); r[31:24] = a[31:24] + 8'(d3);
    return r;
  endfunction

  task automatic fill(input logic [31:0] a, input int lo, input int span);
    blk[0] = a;
    for (int i = 1; i < 64; i++)
      blk[i] = add_d(a, int'($urandom % span) + lo, int'($urandom % span) + lo,
                     int'($urandom % span) + lo, int'($urandom % span) + lo);
  endtask

  bit timed_out = 0;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(in_ready == 1 && out_valid == 0, "R1",
              $sformatf("in reset in_ready %b out_valid %b, expected 1 0", in_ready, out_valid));
        rst_n = 1;
        @(negedge clk);
        check(in_ready == 1 && out_valid == 0, "R1",
              $sformatf("after reset in_ready %b out_valid %b, expected 1 0", in_ready, out_valid));
        for (int i = 0; i < 64; i++) blk[i] = 32'h11223344;
        send_block("R3");
        fill(32'h80408020, -2, 4); blk[1] = add_d(blk[0], 1, 0, 0, 0);
        send_block("R4");
        fill(32'h60a0c030, -8, 16); blk[5] = add_d(blk[0], -8, 7, 0, 0);
        send_block("R5");
        blk[9] = add_d(blk[0], 8, 0, 0, 0);
        send_block("R6");
        for (int i = 0; i < 64; i++) blk[i] = 32'h00ff00ff;
        blk[0] = 32'hff00ff00;
        send_block("R7");
        for (int i = 0; i < 64; i++) blk[i] = $urandom;
        send_block("R6");
        for (int i = 0; i < 64; i++) blk[i] = 32'hcafe0001;
        send_block("R9");
        for (int i = 0; i < 64; i++) blk[i] = 32'h40404040;
        blk[63] = 32'h40404042;
        send_block("R5");
        fill(32'h10203040, -2, 4); blk[2] = add_d(blk[0], -2, 1, -2, 1);
        send_block("R4");
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(in_ready == 1 && out_valid == 0, "R9",
              $sformatf("after last sector in_ready %b out_valid %b, expected 1 0", in_ready, out_valid));
      end
      begin
        repeat (LIMIT) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) check(0, "R2", "watchdog expired: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule